// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction address of a small controller and decides, once per instruction step, where the next instruction comes from. The address is 12 bits wide. The upper 2 bits select one of four 1024-word pages, and the lower 10 bits are the offset within that page. Page bits come from a 2-bit page selection that the status logic supplies. The decoder presents one operation code per step: sequential advance, jump, call, return, add or move of the accumulator into the counter, or a software trap. A level interrupt request can divert a sequential step to the hardware vector.

A 5-level return stack keeps the return addresses for calls and traps. A return restores the full 12-bit address, including the caller's page, and ignores the current page selection. Any write of the accumulator into the counter clears offset bits 9 and 8, so computed jumps reach only the first 256 words of a page. For one cycle after every step that leaves the sequential path, the block raises a flag so the fetch logic can spend the extra instruction cycle that such a step costs.

Top module: `paged_pc`

## Requirements
- R1: While reset is active and after it is released, `pc_o` is 0xFFF and `flush_o` is low, and every stack entry holds 0x000.
- R2: On a step with code 0 or 7 and no taken interrupt, `pc_o` becomes `pc_o`+1 modulo 4096 (0xFFF wraps to 0x000).
- R3: On a step with code 1 (jump), `pc_o` becomes {`page_i`, `imm_i`}.
- R4: On a step with code 2 (call), the value `pc_o`+1 is pushed, and `pc_o` becomes {`page_i`, `imm_i`}.
- R5: On a step with code 3 (return), `pc_o` takes the top stack entry and the stack pops. `page_i` has no effect on this step.
- R6: Code 4 (add) sets `pc_o`[7:0] to (low 8 bits of `pc_o`+1) + `acc_i` modulo 256. Code 5 (move) sets `pc_o`[7:0] to `acc_i`. For both codes, `pc_o`[9:8] becomes 0 and `pc_o`[11:10] becomes `page_i`.
- R7: Code 6 (software trap) pushes `pc_o`+1 and loads 0x002. When `irq_i` is high on a step with code 0 or 7, the block pushes `pc_o`+1 and loads 0x001. When `irq_i` is high on a step with any other code, the interrupt has no effect on that step.
- R8: A push onto a stack that already holds 5 entries discards the oldest entry.
- R9: A pop keeps the bottom entry in place, so a pop from a stack that is already empty returns that bottom value again.
- R10: When `step_i` is low, `pc_o` and the stack hold their values, whatever the other inputs are.
- R11: `flush_o` is high for exactly the cycle that follows a step taking codes 1 to 6 or a taken interrupt. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Executes one instruction step in this cycle |
| op_i | input | 3 | Operation code: 0 seq, 1 jump, 2 call, 3 return, 4 add acc, 5 move acc, 6 trap, 7 seq |
| imm_i | input | 10 | In-page target for jump and call |
| acc_i | input | 8 | Accumulator value for computed writes |
| page_i | input | 2 | Page-select bits from the status register |
| irq_i | input | 1 | Hardware interrupt request |
| pc_o | output | 12 | Current instruction address |
| flush_o | output | 1 | Extra instruction cycle needed for the previous step |

## Verification
The assertions assume that `op_i`, `imm_i`, `acc_i`, `page_i` and `irq_i` are stable and known whenever `step_i` is high. They also assume that the checks start only once the internal reset has been released. The stimulus drives every input at the falling clock edge and holds it through the next rising edge. Input values change only after the reset synchroniser has let go. Hold steps with `step_i` low carry deliberately conflicting codes, so that they test that those inputs are ignored and not that the inputs are quiet.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_ADDA = 3'd4,
    OP_MOVA = 3'd5,
    OP_SWI  = 3'd6,
    OP_RSV  = 3'd7
  } pc_op_e;
endpackage

// File: rtl/ppc_next.sv
module ppc_next
  import ppc_pkg::*;
#(
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned OFS_W   = 10,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned HWI_VEC = 1,
  parameter int unsigned SWI_VEC = 2,
  localparam int unsigned PC_W   = PAGE_W + OFS_W
) (
  input  pc_op_e             op,
  input  logic [PC_W-1:0]    pc,
  input  logic [OFS_W-1:0]   imm,
  input  logic [ACC_W-1:0]   acc,
  input  logic [PAGE_W-1:0]  page,
  input  logic               irq,
  input  logic [PC_W-1:0]    stk_top,
  output logic [PC_W-1:0]    nxt_pc,
  output logic [PC_W-1:0]    push_val,
  output logic               push,
  output logic               pop,
  output logic               redirect
);
  localparam int unsigned GAP_W = OFS_W - ACC_W;

  logic [PC_W-1:0]  seq_pc;
  logic [ACC_W-1:0] sum_lo;

  always_comb begin
    seq_pc   = pc + PC_W'(1);
    sum_lo   = seq_pc[ACC_W-1:0] + acc;
    push_val = seq_pc;
    nxt_pc   = seq_pc;
    push     = 1'b0;
    pop      = 1'b0;
    redirect = 1'b1;
    case (op)
      OP_JMP:  nxt_pc = {page, imm};
      OP_CALL: begin
        nxt_pc = {page, imm};
        push   = 1'b1;
      end
      OP_RET: begin
        nxt_pc = stk_top;
        pop    = 1'b1;
      end
      OP_ADDA: nxt_pc = {page, {GAP_W{1'b0}}, sum_lo};
      OP_MOVA: nxt_pc = {page, {GAP_W{1'b0}}, acc};
      OP_SWI: begin
        nxt_pc = PC_W'(SWI_VEC);
        push   = 1'b1;
      end
      default: begin
        if (irq) begin
          nxt_pc = PC_W'(HWI_VEC);
          push   = 1'b1;
        end else begin
          redirect = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/ppc_stack.sv
module ppc_stack #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  wire [DEPTH*W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] q;
    logic [W-1:0] d;
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    if (i == 0) begin : g_first
      assign from_above = din;
    end else begin : g_rest
      assign from_above = flat[(i-1)*W +: W];
    end

    if (i == DEPTH - 1) begin : g_last
      assign from_below = q;
    end else begin : g_inner
      assign from_below = flat[(i+1)*W +: W];
    end

    always_comb begin
      d = q;
      if (push)     d = from_above;
      else if (pop) d = from_below;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign flat[i*W +: W] = q;
  end

  assign top = flat[W-1:0];
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import ppc_pkg::*;
#(
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned OFS_W   = 10,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned DEPTH   = 5,
  parameter int unsigned RST_VEC = 12'hFFF,
  parameter int unsigned HWI_VEC = 12'h001,
  parameter int unsigned SWI_VEC = 12'h002,
  localparam int unsigned PC_W   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [2:0]        op_i,
  input  logic [OFS_W-1:0]  imm_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              irq_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              flush_o
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] ret_val, top_val;
  logic            do_push, do_pop, redir;
  logic            flush_q, flush_d;

  ppc_next #(
    .PAGE_W (PAGE_W),
    .OFS_W  (OFS_W),
    .ACC_W  (ACC_W),
    .HWI_VEC(HWI_VEC),
    .SWI_VEC(SWI_VEC)
  ) u_next (
    .op      (pc_op_e'(op_i)),
    .pc      (pc_q),
    .imm     (imm_i),
    .acc     (acc_i),
    .page    (page_i),
    .irq     (irq_i),
    .stk_top (top_val),
    .nxt_pc  (pc_d),
    .push_val(ret_val),
    .push    (do_push),
    .pop     (do_pop),
    .redirect(redir)
  );

  ppc_stack #(
    .W    (PC_W),
    .DEPTH(DEPTH)
  ) u_stack (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .en   (step_i),
    .push (do_push),
    .pop  (do_pop),
    .din  (ret_val),
    .top  (top_val)
  );

  always_comb flush_d = step_i & redir;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      pc_q    <= PC_W'(RST_VEC);
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
      if (step_i) pc_q <= pc_d;
    end
  end

  assign pc_o    = pc_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker
  import ppc_pkg::*;
#(
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned OFS_W   = 10,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned HWI_VEC = 1,
  parameter int unsigned SWI_VEC = 2,
  localparam int unsigned PC_W   = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              srst_n,
  input logic              step,
  input logic [2:0]        op,
  input logic [OFS_W-1:0]  imm,
  input logic [PAGE_W-1:0] page,
  input logic              irq,
  input logic [PC_W-1:0]   pc,
  input logic              flush
);
  logic is_seq;
  assign is_seq = (op == OP_SEQ) || (op == OP_RSV);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (step && is_seq && !irq) |=> (pc == $past(pc) + PC_W'(1)) && !flush);

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (step && op == OP_JMP) |=> (pc == {$past(page), $past(imm)}) && flush);

  assert_computed_clear_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (step && (op == OP_ADDA || op == OP_MOVA)) |=>
      (pc[OFS_W-1:ACC_W] == '0) && (pc[PC_W-1:OFS_W] == $past(page)));

  assert_trap_vector_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (step && op == OP_SWI) |=> (pc == PC_W'(SWI_VEC)) && flush);

  assert_irq_vector_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (step && is_seq && irq) |=> (pc == PC_W'(HWI_VEC)) && flush);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!srst_n)
    !step |=> $stable(pc) && !flush);
endmodule

bind paged_pc ppc_checker #(
  .PAGE_W (PAGE_W),
  .OFS_W  (OFS_W),
  .ACC_W  (ACC_W),
  .HWI_VEC(HWI_VEC),
  .SWI_VEC(SWI_VEC)
) u_ppc_checker (
  .clk   (clk),
  .srst_n(rst_sync_q),
  .step  (step_i),
  .op    (op_i),
  .imm   (imm_i),
  .page  (page_i),
  .irq   (irq_i),
  .pc    (pc_o),
  .flush (flush_o)
);

// File: tb/test_paged_pc.sv
module test_paged_pc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [2:0]  op_i;
  logic [9:0]  imm_i;
  logic [7:0]  acc_i;
  logic [1:0]  page_i;
  logic        irq_i;
  logic [11:0] pc_o;
  logic        flush_o;

  always #2.5 clk = ~clk;

  paged_pc i_paged_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_i),
    .op_i   (op_i),
    .imm_i  (imm_i),
    .acc_i  (acc_i),
    .page_i (page_i),
    .irq_i  (irq_i),
    .pc_o   (pc_o),
    .flush_o(flush_o)
  );

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  logic [11:0] exp_pc_q[$];
  logic        exp_fl_q[$];
  string       tag_q[$];

  logic [11:0] mpc;
  logic [11:0] mstk [5];

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic mpush(input logic [11:0] v);
    for (int k = 4; k > 0; k--) mstk[k] = mstk[k-1];
    mstk[0] = v;
  endtask

  task automatic mpop(output logic [11:0] v);
    v = mstk[0];
    for (int k = 0; k < 4; k++) mstk[k] = mstk[k+1];
  endtask

  task automatic step(input logic a, input logic [2:0] op, input logic [9:0] imm,
                      input logic [7:0] acc, input logic [1:0] pg, input logic irq,
                      input string tag);
    logic [11:0] seq, v;
    logic [7:0]  lo;
    logic        fl;
    @(negedge clk);
    step_i = a; op_i = op; imm_i = imm; acc_i = acc; page_i = pg; irq_i = irq;
    seq = mpc + 12'd1;
    fl  = 1'b0;
    if (a) begin
      fl = 1'b1;
      case (op)
        3'd1: mpc = {pg, imm};
        3'd2: begin mpush(seq); mpc = {pg, imm}; end
        3'd3: begin mpop(v); mpc = v; end
        3'd4: begin lo = seq[7:0] + acc; mpc = {pg, 2'b00, lo}; end
        3'd5: mpc = {pg, 2'b00, acc};
        3'd6: begin mpush(seq); mpc = 12'h002; end
        default: begin
          if (irq) begin mpush(seq); mpc = 12'h001; end
          else begin mpc = seq; fl = 1'b0; end
        end
      endcase
    end
    exp_pc_q.push_back(mpc);
    exp_fl_q.push_back(fl);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_pc_q.size() > 0) begin
      logic [11:0] ep;
      logic        ef;
      string       t;
      ep = exp_pc_q.pop_front();
      ef = exp_fl_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (pc_o !== ep || flush_o !== ef) begin
        fails++;
        $display("FAIL %s: pc=%03h flush=%0b expected pc=%03h flush=%0b",
                 t, pc_o, flush_o, ep, ef);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; step_i = 1'b0; op_i = 3'd0; imm_i = '0; acc_i = '0;
    page_i = '0; irq_i = 1'b0;
    mpc = 12'hFFF;
    for (int k = 0; k < 5; k++) mstk[k] = 12'h000;
    repeat (3) @(negedge clk);
    checks++;
    if (pc_o !== 12'hFFF || flush_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: pc=%03h flush=%0b expected pc=fff flush=0", pc_o, flush_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (pc_o !== 12'hFFF || flush_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 after release: pc=%03h flush=%0b expected pc=fff flush=0", pc_o, flush_o);
    end

    // R2 wrap, R1/R9 zeroed bottom entry
    step(1, 3'd0, 10'h000, 8'h00, 2'd0, 0, "R2 wrap fff->000");
    step(1, 3'd3, 10'h000, 8'h00, 2'd3, 0, "R1 R9 pop of reset stack");
    step(1, 3'd7, 10'h000, 8'h00, 2'd0, 0, "R2 code 7 sequential");
    // R3 jump
    step(1, 3'd1, 10'h155, 8'h00, 2'd2, 0, "R3 jump page 2");
    step(1, 3'd0, 10'h000, 8'h00, 2'd0, 0, "R11 flush drops after seq");
    // R4 call, R5 return ignores page
    step(1, 3'd2, 10'h3A0, 8'h00, 2'd1, 0, "R4 call page 1");
    step(1, 3'd3, 10'h000, 8'h00, 2'd3, 0, "R5 return to caller page");
    // R8 overflow: six nested calls
    for (int n = 0; n < 6; n++)
      step(1, 3'd2, 10'(10'h040 * n + 10'h011), 8'h00, 2'(n), 0, "R8 nested call");
    // R5 R9 drain beyond depth
    for (int n = 0; n < 7; n++)
      step(1, 3'd3, 10'h000, 8'h00, 2'(n), 0, "R9 return chain");
    // R6 computed writes
    step(1, 3'd1, 10'h2F0, 8'h00, 2'd0, 0, "R3 jump setup");
    step(1, 3'd4, 10'h000, 8'h20, 2'd1, 0, "R6 add wraps low byte");
    step(1, 3'd4, 10'h3FF, 8'h05, 2'd2, 0, "R6 add small");
    step(1, 3'd5, 10'h3FF, 8'hAB, 2'd3, 0, "R6 move acc");
    // R7 trap and interrupt
    step(1, 3'd6, 10'h000, 8'h00, 2'd1, 0, "R7 software trap");
    step(1, 3'd3, 10'h000, 8'h00, 2'd0, 0, "R5 return from trap");
    step(1, 3'd0, 10'h000, 8'h00, 2'd0, 1, "R7 irq on sequential step");
    step(1, 3'd3, 10'h000, 8'h00, 2'd2, 0, "R5 return from irq");
    step(1, 3'd1, 10'h100, 8'h00, 2'd0, 1, "R7 irq ignored on jump");
    step(1, 3'd7, 10'h000, 8'h00, 2'd0, 1, "R7 irq on code 7");
    // R10 hold with conflicting inputs
    step(0, 3'd1, 10'h3FF, 8'hFF, 2'd3, 0, "R10 hold jump ignored");
    step(0, 3'd2, 10'h123, 8'h00, 2'd2, 1, "R10 hold call ignored");
    step(1, 3'd3, 10'h000, 8'h00, 2'd0, 0, "R10 stack kept during hold");
    step(1, 3'd0, 10'h000, 8'h00, 2'd0, 0, "R2 seq after return");
    repeat (3) @(negedge clk);
    report();
  end
endmodule